// File: doc/BRIEF.md
# I2C Slave Read-Data Transmitter with Burst FIFO

This block is the transmit half of an I2C slave. It watches the bus for a START, shifts in the address byte and answers only when the seven address bits equal `own_addr` and the direction bit asks for a read. After it acknowledges, it raises `irq` and holds SCL low. Software then loads any number of bytes into a 16-entry FIFO through a one-byte write port and pulses `irq_clr`. The block then sends every byte held, most significant bit first, back to back.

If the master acknowledges a byte and the FIFO is empty, the block raises `irq` again, sets `tx_empty` and stretches the clock until software refills the FIFO. A master NACK silences the block until the next bus condition. A STOP or a repeated START that ends an acknowledged transfer sets `xfer_end`. Software clears that flag and discards any bytes still in the FIFO. The bus pins are open-drain: the block only reports when it pulls each line low.

Top module: `i2c_slave_txfifo`

## Requirements
- R1: An address byte whose upper seven bits equal `own_addr` and whose bit 0 is 1 is acknowledged with SDA low during the ninth clock. On the falling edge of that clock `irq` is set and SCL is held low. The address byte never enters the FIFO, so `fifo_level` stays 0.
- R2: An address byte with other upper bits, or with bit 0 equal to 0, gets no acknowledge (SDA stays released). It sets neither `irq` nor `xfer_end`.
- R3: While `irq` is pending inside a transfer, SCL is held low. After `irq_clr` with a non-empty FIFO, the block sends every held byte, MSB first, and releases SCL.
- R4: When the master acknowledges a byte and the FIFO is empty, `irq` and `tx_empty` are set and SCL is stretched. Any host write clears `tx_empty`. Refilling the FIFO and pulsing `irq_clr` resumes transmission.
- R5: After a master NACK the block drives SDA no more until the next START or STOP. Unsent bytes stay in the FIFO.
- R6: A STOP that ends an acknowledged transfer sets `xfer_end`, and SCL is not held low afterwards.
- R7: A repeated START that ends an acknowledged transfer sets `xfer_end`.
- R8: `xfer_end_clr` clears `xfer_end`. `fifo_clr` empties the FIFO and clears `fifo_overflow`.
- R9: The FIFO holds 16 bytes. A write to a full FIFO is dropped, leaves `fifo_level` at 16 and sets the sticky `fifo_overflow`.
- R10: SDA changes only while SCL is low. Both bus lines pass through a 2-flop synchronizer before START and STOP are detected.
- R11: After reset `irq`, `tx_empty`, `xfer_end`, `fifo_overflow`, both drive outputs and `fifo_level` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level |
| scl_drive_low | output | 1 | 1 pulls SCL low |
| sda_drive_low | output | 1 | 1 pulls SDA low |
| own_addr | input | 7 | Slave address to match |
| wr_en | input | 1 | Host FIFO write strobe |
| wr_data | input | 8 | Byte to append to the FIFO |
| fifo_clr | input | 1 | Empty the FIFO and clear overflow |
| irq_clr | input | 1 | Clear the interrupt flag |
| xfer_end_clr | input | 1 | Clear the transfer-end flag |
| irq | output | 1 | Interrupt flag |
| tx_empty | output | 1 | FIFO ran empty during a transfer |
| xfer_end | output | 1 | Transfer ended by STOP or repeated START |
| fifo_overflow | output | 1 | Sticky: a write hit a full FIFO |
| fifo_level | output | 5 | Bytes held in the FIFO |

## Verification
A wrong bit counter or shift register shows up as a corrupted byte that the master reads on the very next transfer. A wrong state after an acknowledge shows up as a missing or stuck clock stretch. Either one hangs the master's clock or raises the interrupt at the wrong moment, and the stretch can be observed within a few cycles of the SCL falling edge. FIFO pointer or count faults appear on the level output on the clock after a write or a clear. They also appear as dropped or repeated bytes once the FIFO is drained over the bus. A stuck transfer-end or NACK state is exposed by SDA being pulled while the master expects silence, or by the end flag missing after STOP.

// File: rtl/i2cst_pkg.sv
package i2cst_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_AMAT, ST_AACK, ST_HOLD,
    ST_LOAD, ST_TX, ST_RACK, ST_DEAF
  } stx_e;

  // address byte selects this slave for a read
  function automatic logic addr_hit(input logic [7:0] abyte, input logic [6:0] own);
    return (abyte[7:1] == own) && abyte[0];
  endfunction

endpackage

// File: rtl/i2cst_sync.sv
module i2cst_sync #(
  parameter int LINES  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] din,
  output logic [LINES-1:0] dout
);
  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES-1:0] pipe;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe <= '1;
      else        pipe <= {pipe[STAGES-2:0], din[g]};
    end
    assign dout[g] = pipe[STAGES-1];
  end
endmodule

// File: rtl/i2cst_fifo.sv
module i2cst_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  input  logic          clear,
  output logic [DW-1:0] head,
  output logic          empty,
  output logic [AW:0]   level,
  output logic          overflow
);
  localparam logic [AW:0] FULL_LVL = (AW+1)'(DEPTH);

  function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] rp, wp;
  logic [AW:0]   cnt;
  logic          full, take, give;

  assign full  = (cnt == FULL_LVL);
  assign empty = (cnt == '0);
  assign take  = push & ~full & ~clear;
  assign give  = pop & ~empty & ~clear;
  assign head  = mem[rp];
  assign level = cnt;

  always_ff @(posedge clk) if (take) mem[wp] <= push_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rp <= '0; wp <= '0; cnt <= '0; overflow <= 1'b0;
    end else if (clear) begin
      rp <= '0; wp <= '0; cnt <= '0; overflow <= 1'b0;
    end else begin
      if (take) wp <= ptr_next(wp);
      if (give) rp <= ptr_next(rp);
      case ({take, give})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
      if (push && full) overflow <= 1'b1;
    end
  end

  // R9
  full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !clear && !pop) |=> (overflow && level == FULL_LVL));
  // R9
  level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    level <= FULL_LVL);
  // R5
  pop_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
endmodule

// File: rtl/i2cst_core.sv
module i2cst_core
  import i2cst_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_s,
  input  logic       sda_s,
  input  logic [6:0] own_addr,
  input  logic       fifo_empty,
  input  logic [7:0] fifo_head,
  input  logic       host_wr,
  input  logic       irq_clr,
  input  logic       end_clr,
  output logic       pop,
  output logic       scl_low,
  output logic       sda_low,
  output logic       irq,
  output logic       tx_empty,
  output logic       xfer_end
);
  stx_e       state;
  logic [7:0] shreg;
  logic [2:0] bitcnt;
  logic       scl_q, sda_q, got_ack, engaged;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin scl_q <= 1'b1; sda_q <= 1'b1; end
    else        begin scl_q <= scl_s; sda_q <= sda_s; end
  end

  // named bus events
  logic scl_rise, scl_fall, start_evt, stop_evt, end_evt, refill_go, ack_empty;
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_evt = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_evt  = scl_s & scl_q & ~sda_q & sda_s;
  assign end_evt   = engaged & (start_evt | stop_evt);
  assign refill_go = (state == ST_HOLD) & ~irq & ~fifo_empty;
  assign ack_empty = (state == ST_RACK) & scl_fall & got_ack & fifo_empty;

  assign pop     = refill_go | ((state == ST_RACK) & scl_fall & got_ack & ~fifo_empty);
  assign scl_low = (state == ST_HOLD) | (state == ST_LOAD);
  assign sda_low = (state == ST_AACK) |
                   (((state == ST_TX) | (state == ST_LOAD)) & ~shreg[7]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE; shreg <= '0; bitcnt <= '0; got_ack <= 1'b0;
      engaged <= 1'b0; irq <= 1'b0; tx_empty <= 1'b0; xfer_end <= 1'b0;
    end else begin
      if (irq_clr) irq <= 1'b0;
      if (host_wr) tx_empty <= 1'b0;
      if (end_clr) xfer_end <= 1'b0;
      if (end_evt) xfer_end <= 1'b1;
      if (start_evt) begin
        state <= ST_ADDR; bitcnt <= '0; engaged <= 1'b0;
      end else if (stop_evt) begin
        state <= ST_IDLE; engaged <= 1'b0;
      end else begin
        case (state)
          ST_ADDR: if (scl_rise) begin
            shreg  <= {shreg[6:0], sda_s};
            bitcnt <= bitcnt + 1'b1;
            if (bitcnt == 3'd7) state <= ST_AMAT;
          end
          ST_AMAT: if (scl_fall) begin
            if (addr_hit(shreg, own_addr)) begin
              state <= ST_AACK; engaged <= 1'b1;
            end else state <= ST_DEAF;
          end
          ST_AACK: if (scl_fall) begin
            state <= ST_HOLD; irq <= 1'b1;
          end
          ST_HOLD: if (refill_go) begin
            state <= ST_LOAD; shreg <= fifo_head; bitcnt <= '0;
          end
          ST_LOAD: state <= ST_TX;
          ST_TX: if (scl_fall) begin
            if (bitcnt == 3'd7) state <= ST_RACK;
            else begin
              shreg  <= {shreg[6:0], 1'b0};
              bitcnt <= bitcnt + 1'b1;
            end
          end
          ST_RACK: begin
            if (scl_rise) got_ack <= ~sda_s;
            if (scl_fall) begin
              if (!got_ack) state <= ST_DEAF;
              else if (!fifo_empty) begin
                state <= ST_TX; shreg <= fifo_head; bitcnt <= '0;
              end else begin
                state <= ST_HOLD; irq <= 1'b1; tx_empty <= 1'b1;
              end
            end
          end
          default: state <= state;
        endcase
      end
    end
  end

  // R10
  sda_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_low) |-> !scl_s);
  // R6
  end_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    end_evt |=> (xfer_end && !scl_low));
  // R1
  addr_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_AACK && scl_fall && !start_evt && !stop_evt) |=> (irq && scl_low));
  // R4
  empty_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_empty && !start_evt && !stop_evt) |=> (irq && tx_empty && scl_low));
endmodule

// File: rtl/i2c_slave_txfifo.sv
module i2c_slave_txfifo #(
  parameter int DEPTH = 16,
  localparam int LW   = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_in,
  input  logic          sda_in,
  output logic          scl_drive_low,
  output logic          sda_drive_low,
  input  logic [6:0]    own_addr,
  input  logic          wr_en,
  input  logic [7:0]    wr_data,
  input  logic          fifo_clr,
  input  logic          irq_clr,
  input  logic          xfer_end_clr,
  output logic          irq,
  output logic          tx_empty,
  output logic          xfer_end,
  output logic          fifo_overflow,
  output logic [LW-1:0] fifo_level
);
  logic [1:0] lines_s;
  logic       f_empty, f_pop;
  logic [7:0] f_head;

  i2cst_sync #(.LINES(2), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .din({scl_in, sda_in}), .dout(lines_s));

  i2cst_fifo #(.DW(8), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(wr_en), .push_data(wr_data),
    .pop(f_pop), .clear(fifo_clr), .head(f_head), .empty(f_empty),
    .level(fifo_level), .overflow(fifo_overflow));

  i2cst_core u_core (
    .clk(clk), .rst_n(rst_n), .scl_s(lines_s[1]), .sda_s(lines_s[0]),
    .own_addr(own_addr), .fifo_empty(f_empty), .fifo_head(f_head),
    .host_wr(wr_en), .irq_clr(irq_clr), .end_clr(xfer_end_clr),
    .pop(f_pop), .scl_low(scl_drive_low), .sda_low(sda_drive_low),
    .irq(irq), .tx_empty(tx_empty), .xfer_end(xfer_end));
endmodule

// File: tb/i2c_slave_txfifo_test.sv
`timescale 1ns/1ps
module i2c_slave_txfifo_test;
  localparam int HP = 20;
  localparam logic [6:0] ME = 7'h2A;

  logic clk = 0, rst_n = 0;
  logic scl_m = 1, sda_m = 1;
  logic wr_en = 0, fifo_clr = 0, irq_clr = 0, xfer_end_clr = 0;
  logic [7:0] wr_data = '0;
  logic scl_dl, sda_dl, irq, tx_empty, xfer_end, ovf;
  logic [4:0] level;
  wire scl_bus = scl_m & ~scl_dl;
  wire sda_bus = sda_m & ~sda_dl;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [7:0] exp_q [$];
  bit m_ovf = 0;

  always #4 clk = ~clk;

  i2c_slave_txfifo uut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_bus), .sda_in(sda_bus),
    .scl_drive_low(scl_dl), .sda_drive_low(sda_dl), .own_addr(ME),
    .wr_en(wr_en), .wr_data(wr_data), .fifo_clr(fifo_clr), .irq_clr(irq_clr),
    .xfer_end_clr(xfer_end_clr), .irq(irq), .tx_empty(tx_empty),
    .xfer_end(xfer_end), .fifo_overflow(ovf), .fifo_level(level));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // per-clock model comparison of the overflow flag (R9)
  always @(posedge clk) begin
    #3;
    if (rst_n && !done) chk("R9 overflow model", ovf, m_ovf);
  end

  task automatic wt(input int n); repeat (n) @(negedge clk); endtask
  task automatic wait_scl_high; while (scl_bus !== 1'b1) @(negedge clk); endtask

  task automatic host_write(input logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_data = d;
    @(posedge clk); #1;
    if (exp_q.size() < 16) exp_q.push_back(d); else m_ovf = 1;
    @(negedge clk); wr_en = 0;
  endtask
  task automatic host_fifo_clear;
    @(negedge clk); fifo_clr = 1;
    @(posedge clk); #1; exp_q.delete(); m_ovf = 0;
    @(negedge clk); fifo_clr = 0;
  endtask
  task automatic pulse_irq_clr;  @(negedge clk); irq_clr = 1; @(negedge clk); irq_clr = 0; endtask
  task automatic pulse_end_clr;  @(negedge clk); xfer_end_clr = 1; @(negedge clk); xfer_end_clr = 0; endtask

  task automatic bus_start;
    sda_m = 1; scl_m = 1; wt(HP); sda_m = 0; wt(HP); scl_m = 0; wt(4);
  endtask
  task automatic bus_rstart;
    sda_m = 1; wt(HP); scl_m = 1; wait_scl_high(); wt(HP); sda_m = 0; wt(HP); scl_m = 0; wt(4);
  endtask
  task automatic bus_stop;
    sda_m = 0; wt(HP); scl_m = 1; wait_scl_high(); wt(HP); sda_m = 1; wt(HP);
  endtask
  task automatic put_bit(input logic b);
    sda_m = b; wt(HP); scl_m = 1; wait_scl_high(); wt(HP); scl_m = 0; wt(4);
  endtask
  task automatic get_bit(output logic b);
    sda_m = 1; wt(HP); scl_m = 1; wait_scl_high(); wt(HP / 2); b = sda_bus;
    wt(HP / 2); scl_m = 0; wt(4);
  endtask
  task automatic send_addr(input logic [7:0] a, output logic ackbit);
    bus_start();
    for (int i = 7; i >= 0; i--) put_bit(a[i]);
    get_bit(ackbit);
  endtask
  task automatic read_byte(input logic nack, input string req);
    logic [7:0] d; logic b; logic [7:0] e;
    d = '0;
    for (int i = 0; i < 8; i++) begin get_bit(b); d = {d[6:0], b}; end
    put_bit(nack);
    e = (exp_q.size() > 0) ? exp_q.pop_front() : 8'hxx;
    chk(req, d, e);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1; checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic ack;
    int cnt;
    wt(5);
    // R11 reset state
    chk("R11 irq", irq, 0); chk("R11 tx_empty", tx_empty, 0);
    chk("R11 xfer_end", xfer_end, 0); chk("R11 level", level, 0);
    chk("R11 drives", {scl_dl, sda_dl}, 0);
    rst_n = 1; wt(5);

    // R2 wrong address, read direction
    send_addr({7'h15, 1'b1}, ack);
    chk("R2 no ack wrong addr", ack, 1); wt(10); chk("R2 no irq", irq, 0);
    bus_stop(); wt(10); chk("R2 no xfer_end", xfer_end, 0);
    // R2 own address, write direction
    send_addr({ME, 1'b0}, ack);
    chk("R2 no ack write dir", ack, 1); wt(10); chk("R2 no irq write", irq, 0);
    bus_stop(); wt(10); chk("R2 no xfer_end write", xfer_end, 0);

    // R1 match
    send_addr({ME, 1'b1}, ack);
    chk("R1 ack", ack, 0); wt(10);
    chk("R1 irq", irq, 1); chk("R1 stretch", scl_dl, 1); chk("R1 addr not stored", level, 0);
    host_write(8'hA5); host_write(8'h3C); host_write(8'hF0);
    wt(30);
    chk("R3 still stretched", scl_dl, 1); chk("R3 level", level, 3);
    pulse_irq_clr(); chk("R3 irq cleared", irq, 0);
    read_byte(0, "R3 byte0"); read_byte(0, "R3 byte1"); read_byte(0, "R3 byte2");
    wt(10);
    chk("R4 irq empty", irq, 1); chk("R4 tx_empty", tx_empty, 1); chk("R4 stretch", scl_dl, 1);
    host_write(8'h5A);
    chk("R4 tx_empty cleared by write", tx_empty, 0);
    host_write(8'hC3); host_write(8'h12);
    pulse_irq_clr();
    read_byte(0, "R4 refill byte0"); read_byte(1, "R5 nacked byte");
    cnt = 0;
    for (int i = 0; i < 40; i++) begin @(negedge clk); if (sda_dl) cnt++; end
    chk("R5 sda quiet after nack", cnt, 0);
    chk("R5 leftover kept", level, 1);
    chk("R5 no irq after nack", irq, 0);
    bus_stop(); wt(10);
    chk("R6 xfer_end on stop", xfer_end, 1); chk("R6 scl released", scl_dl, 0);
    pulse_end_clr(); chk("R8 xfer_end cleared", xfer_end, 0);
    host_fifo_clear(); chk("R8 fifo emptied", level, 0);

    // R7 repeated start ends transfer
    send_addr({ME, 1'b1}, ack);
    chk("R7 ack", ack, 0); wt(10);
    host_write(8'h81); pulse_irq_clr();
    read_byte(1, "R7 byte");
    bus_rstart(); wt(10);
    chk("R7 xfer_end on rstart", xfer_end, 1);
    for (int i = 7; i >= 0; i--) put_bit(8'h10 >> i);
    get_bit(ack); chk("R7 readdress other", ack, 1);
    bus_stop(); pulse_end_clr();

    // R9 overflow: 17 writes, 17th dropped
    for (int i = 0; i < 17; i++) host_write(8'h40 + 8'(i * 3));
    chk("R9 level full", level, 16); chk("R9 overflow set", ovf, 1);
    send_addr({ME, 1'b1}, ack);
    chk("R9 ack", ack, 0); wt(10);
    pulse_irq_clr();
    for (int i = 0; i < 16; i++) read_byte(i == 15, "R9 drained byte");
    bus_stop(); wt(10);
    chk("R9 fifo drained", level, 0);
    host_fifo_clear(); chk("R8 overflow cleared", ovf, 0);
    pulse_end_clr();

    wt(10);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule